// File: doc/BRIEF.md
# Key-Guarded Configuration Register

This block holds one 32-bit configuration word for analog-test switching or supply-monitor settings. A write is applied only when the top byte of the same write word carries the fixed key 0x5A. Any other key byte leaves the stored word unchanged. The key byte is never stored and always reads back as zero. The writable fields appear on a parallel output for the analog logic they control. They also appear on a read port, together with reserved positions that read as zero.

The write side is a plain strobe (`wr_en`) qualified by a select (`sel`). The block never applies back-pressure: it completes every selected write in the clock edge where the strobe is seen, whether it accepts or rejects it. Each rejected write produces a one-cycle pulse on `key_reject`. An external lock input (`glock`) protects the fields named in a protection mask: while it is high, an accepted write still updates every other writable field but leaves the protected ones as they were. A parameter picks the field layout. In the default analog-test layout, bits 8:0 are writable, bit 8 is the protected supply-select field, and the reset value is 0x0000_000F, with the four ground-shorting switches in bits 3:0 closed.

Top module: `keyguard_cfg_reg`

## Requirements
- R1: A selected write whose bits 31:24 equal 0x5A updates every writable bit (bits 8:0 in the default layout) in the same clock edge. The new value is visible on `rd_data` and `cfg_q` from the next cycle, and `cfg_q` always equals `rd_data[23:0]`.
- R2: A selected write whose bits 31:24 differ from 0x5A is ignored completely, and the stored word keeps its contents.
- R3: `rd_data[31:24]` reads 0x00 at all times, including after writes that carry the key.
- R4: After reset, the default layout reads 0x0000_000F: bits 3:0 are one, and bits 8:4 are zero.
- R5: Reserved bits (bits 23:9 in the default layout) always read zero, and writing ones to them has no effect.
- R6: `key_reject` is high for exactly the one cycle after each rejected write, and is low after accepted writes, unselected writes and idle cycles.
- R7: While `glock` is high, an accepted write leaves the protected bits (bit 8 by default) unchanged and still updates all other writable bits.
- R8: A strobe with `sel` low changes nothing and raises no `key_reject`, even when its key byte is correct.
- R9: Asserting reset restores the reset value and clears `key_reject`, whatever writes came before.
- R10: Writes on consecutive cycles are each applied or rejected on their own, in order, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select from the bus decoder |
| wr_en | input | 1 | Write strobe, acts only when `sel` is high |
| wr_data | input | 32 | Write word; bits 31:24 carry the key |
| glock | input | 1 | External lock for the protected fields |
| rd_data | output | 32 | Read-back word; key byte and reserved bits read zero |
| cfg_q | output | 24 | Parallel configuration fields (bits 23:0 of the word) |
| key_reject | output | 1 | One-cycle pulse after each rejected write |

## Verification
All 512 values of the nine writable bits are written with the correct key while reserved bits carry changing junk. This shows whether every field is applied at once and whether the reserved positions stay zero. A sweep over all 256 key byte values, each with a data pattern that differs from the stored word, separates the one accepting key from the 255 rejected ones. It also tests the reject pulse on each. A second full data sweep with the lock high separates the protected bit from the free ones. Unselected writes with a valid key, a single-cycle pulse check and a reset taken after a history of writes cover the remaining paths.

// File: rtl/kgcfg_pkg.sv
package kgcfg_pkg;

  localparam int WORD_W = 32;
  localparam int KEY_W  = 8;
  localparam int CFG_W  = WORD_W - KEY_W;

  typedef enum logic [0:0] {
    LAYOUT_ATEST  = 1'b0,
    LAYOUT_SUPMON = 1'b1
  } layout_e;

  localparam logic [WORD_W-1:0] KEY_FIELD = {{KEY_W{1'b1}}, {CFG_W{1'b0}}};

  function automatic logic [WORD_W-1:0] writable_bits(layout_e lay);
    logic [WORD_W-1:0] m;
    case (lay)
      LAYOUT_ATEST:  m = 32'h0000_01FF;
      LAYOUT_SUPMON: m = 32'h000F_0F03;
      default:       m = '0;
    endcase
    return m & ~KEY_FIELD;
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(layout_e lay);
    logic [WORD_W-1:0] r;
    case (lay)
      LAYOUT_ATEST:  r = 32'h0000_000F;
      default:       r = '0;
    endcase
    return r & writable_bits(lay);
  endfunction

endpackage

// File: rtl/kgcfg_key_gate.sv
module kgcfg_key_gate #(
  parameter int                 KEY_W = 8,
  parameter logic [KEY_W-1:0]   KEY   = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key_byte,
  output logic             wr_go,
  output logic             rej_pulse
);

  logic strobe;
  logic key_ok;

  assign strobe = sel & wr_en;
  assign key_ok = (key_byte == KEY);
  assign wr_go  = strobe & key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_pulse <= 1'b0;
    else        rej_pulse <= strobe & ~key_ok;
  end

endmodule

// File: rtl/kgcfg_store.sv
module kgcfg_store #(
  parameter int                WORD_W    = 32,
  parameter logic [WORD_W-1:0] WMASK     = '0,
  parameter logic [WORD_W-1:0] RSTV      = '0,
  parameter logic [WORD_W-1:0] LOCK_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              glock,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] q
);

  logic unused_rsv;
  assign unused_rsv = ^(wr_data & ~WMASK);

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (WMASK[i]) begin : g_rw
      logic hold;
      logic bit_q;
      assign hold = glock & LOCK_MASK[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              bit_q <= RSTV[i];
        else if (wr_go && !hold) bit_q <= wr_data[i];
      end
      assign q[i] = bit_q;
    end else begin : g_rsv
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/kgcfg_readback.sv
module kgcfg_readback #(
  parameter int                WORD_W = 32,
  parameter int                KEY_W  = 8,
  parameter logic [WORD_W-1:0] WMASK  = '0
) (
  input  logic [WORD_W-1:0]       q,
  output logic [WORD_W-1:0]       rd_data,
  output logic [WORD_W-KEY_W-1:0] cfg_q
);

  localparam int CFG_W = WORD_W - KEY_W;

  logic [WORD_W-1:0] visible;
  assign visible = q & WMASK;
  assign rd_data = {{KEY_W{1'b0}}, visible[CFG_W-1:0]};
  assign cfg_q   = visible[CFG_W-1:0];

  logic unused_top;
  assign unused_top = ^visible[WORD_W-1:CFG_W];

endmodule

// File: rtl/keyguard_cfg_reg.sv
module keyguard_cfg_reg
  import kgcfg_pkg::*;
#(
  parameter layout_e           LAYOUT    = LAYOUT_ATEST,
  parameter logic [KEY_W-1:0]  KEY       = 8'h5A,
  parameter logic [WORD_W-1:0] LOCK_MASK = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              glock,
  output logic [WORD_W-1:0] rd_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              key_reject
);

  localparam logic [WORD_W-1:0] WMASK = writable_bits(LAYOUT);
  localparam logic [WORD_W-1:0] RSTV  = reset_word(LAYOUT);

  logic              wr_go;
  logic [WORD_W-1:0] q;

  kgcfg_key_gate #(.KEY_W(KEY_W), .KEY(KEY)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .key_byte  (wr_data[WORD_W-1:CFG_W]),
    .wr_go     (wr_go),
    .rej_pulse (key_reject)
  );

  kgcfg_store #(
    .WORD_W(WORD_W), .WMASK(WMASK), .RSTV(RSTV), .LOCK_MASK(LOCK_MASK & WMASK)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .glock   (glock),
    .wr_data (wr_data),
    .q       (q)
  );

  kgcfg_readback #(.WORD_W(WORD_W), .KEY_W(KEY_W), .WMASK(WMASK)) u_rb (
    .q       (q),
    .rd_data (rd_data),
    .cfg_q   (cfg_q)
  );

endmodule

// File: rtl/keyguard_cfg_reg_chk.sv
module keyguard_cfg_reg_chk
  import kgcfg_pkg::*;
#(
  parameter layout_e           LAYOUT    = LAYOUT_ATEST,
  parameter logic [KEY_W-1:0]  KEY       = 8'h5A,
  parameter logic [WORD_W-1:0] LOCK_MASK = 32'h0000_0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              glock,
  input logic [WORD_W-1:0] rd_data,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              key_reject
);

  localparam logic [WORD_W-1:0] WM = writable_bits(LAYOUT);
  localparam logic [WORD_W-1:0] LM = LOCK_MASK & WM;

  logic good_wr, bad_wr;
  assign good_wr = sel && wr_en && (wr_data[WORD_W-1:CFG_W] == KEY);
  assign bad_wr  = sel && wr_en && (wr_data[WORD_W-1:CFG_W] != KEY);

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && !glock) |=> (rd_data == ($past(wr_data) & WM)));

  a_r1_cfg_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q == rd_data[CFG_W-1:0]);

  a_r2_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(rd_data));

  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:CFG_W] == '0);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~WM) == '0);

  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> key_reject);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !key_reject);

  a_r7_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
    glock |=> ((rd_data & LM) == ($past(rd_data) & LM)));

  a_r8_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en) |=> $stable(rd_data));

endmodule

bind keyguard_cfg_reg keyguard_cfg_reg_chk #(
  .LAYOUT(LAYOUT), .KEY(KEY), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .glock      (glock),
  .rd_data    (rd_data),
  .cfg_q      (cfg_q),
  .key_reject (key_reject)
);

// File: tb/keyguard_cfg_reg_test.sv
module keyguard_cfg_reg_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        glock;
  logic [31:0] rd_data;
  logic [23:0] cfg_q;
  logic        key_reject;

  localparam logic [31:0] WM   = 32'h0000_01FF;
  localparam logic [31:0] LM   = 32'h0000_0100;
  localparam logic [31:0] RSTW = 32'h0000_000F;
  localparam logic [7:0]  KEYV = 8'h5A;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_w;
  bit done = 0;

  always #4 clk = ~clk;

  keyguard_cfg_reg uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .glock(glock), .rd_data(rd_data), .cfg_q(cfg_q), .key_reject(key_reject)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Starts and ends at a negative edge.
  task automatic do_write(input string tag, input logic s, input logic lk, input logic [31:0] d);
    logic [31:0] upd;
    logic        rej;
    sel = s; wr_en = 1'b1; glock = lk; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; sel = 1'b0;
    rej = 1'b0;
    if (s) begin
      if (d[31:24] == KEYV) begin
        upd   = WM & ~(lk ? LM : 32'h0);
        exp_w = (exp_w & ~upd) | (d & upd);
      end else rej = 1'b1;
    end
    check(tag, rd_data, exp_w);
    check({tag, " cfg"}, {8'h0, cfg_q}, exp_w);
    check({tag, " reject R6"}, {31'h0, key_reject}, {31'h0, rej});
  endtask

  task automatic idle_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, {31'h0, key_reject}, 32'h0);
    check({tag, " hold"}, rd_data, exp_w);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; wr_data = '0; glock = 1'b0;
    exp_w = RSTW;
    repeat (3) @(negedge clk);
    // R4 reset value
    check("R4 reset rd", rd_data, RSTW);
    check("R4 reset cfg", {8'h0, cfg_q}, RSTW);
    check("R9 reset reject", {31'h0, key_reject}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 after release", rd_data, RSTW);

    // R1 R3 R5 R10: every writable value, reserved junk, back-to-back
    for (int i = 0; i < 512; i++) begin
      logic [14:0] junk;
      junk = 15'(i * 37 + 5);
      do_write("R1 R3 R5 R10 sweep", 1'b1, 1'b0, {KEYV, junk, 9'(i)});
    end

    // R2 R6: every key byte
    for (int k = 0; k < 256; k++) begin
      logic [8:0] pat;
      pat = 9'h0A5 ^ 9'(k);
      do_write("R2 key sweep", 1'b1, 1'b0, {8'(k), 15'h7FFF, pat});
      if (k[7:0] != KEYV && k[3:0] == 4'h3) idle_check("R6 single-cycle pulse");
    end

    // R7: lock high, full data sweep
    for (int i = 0; i < 512; i++) begin
      do_write("R7 lock sweep", 1'b1, 1'b1, {KEYV, 15'h0, 9'(511 - i)});
    end
    do_write("R7 unlocked write", 1'b1, 1'b0, {KEYV, 24'h000_1AA});

    // R8: unselected strobe with valid key
    do_write("R8 unselected", 1'b0, 1'b0, {KEYV, 24'h000_055});
    do_write("R8 unselected bad key", 1'b0, 1'b0, {8'h00, 24'h000_0F0});
    idle_check("R8 idle");

    // R9: reset after history
    do_write("R9 pre", 1'b1, 1'b0, {KEYV, 24'h000_1F0});
    do_write("R9 pre reject", 1'b1, 1'b0, {8'hA5, 24'h000_000});
    rst_n = 1'b0;
    exp_w = RSTW;
    @(posedge clk);
    @(negedge clk);
    check("R9 reset value", rd_data, RSTW);
    check("R9 reject cleared", {31'h0, key_reject}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_write("R9 post write", 1'b1, 1'b0, {KEYV, 24'h000_0C3});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule